// File: doc/BRIEF.md
# Inter-Processor Send Command Dispatcher

This block takes 64-bit send commands, one at a time, over a valid/ready input and turns each into an action on a set of per-core register banks. Three command kinds exist. An interrupt send raises one of 32 vector bits in a chosen core. A mail send stores a 32-bit word into one of eight word slots of a core's mailbox area. An any-send stores a 32-bit word at an arbitrary 16-bit register offset of a core.

Mail and any-send carry a four-bit byte keep mask. When the mask is zero the payload is written straight away. When it is non-zero the dispatcher first reads the target word through its read port, keeps the bytes the mask selects, fills the rest from the payload and writes the merged word back. During that read-modify-write the command input is held off. Commands that name a core outside the configured count, use the unassigned kind code, or whose old-word read fails are dropped and reported on a one-cycle error strobe with a code.

Top module: `ipi_send_dispatch`

## Requirements
- R1: The target core is cmd_data[25:16]; a value at or above NUM_CORES drops the command and raises err_valid with err_code 2'b01 in the cycle after acceptance, with no write, read or interrupt.
- R2: Kind 2'b00 (interrupt send) raises irq_set_en for one cycle after acceptance with irq_set_core equal to the target and irq_set_mask equal to 1 shifted left by cmd_data[4:0].
- R3: Kind 2'b01 (mail send) addresses offset 0x20 + 4 * cmd_data[4:2].
- R4: Kind 2'b10 (any-send) addresses offset cmd_data[15:0].
- R5: The payload is cmd_data[63:32]; when the keep mask cmd_data[30:27] is zero the payload is written in the cycle after acceptance and no read is issued.
- R6: When the keep mask is non-zero, bank_rd_en is raised for exactly one cycle, the cycle after acceptance, at the target core and offset; in the cycle after bank_rd_ack without error the merged word is written, byte i coming from bank_rd_data when cmd_data[27+i] is set and from the payload otherwise.
- R7: A bank_rd_ack with bank_rd_err set aborts the command: err_valid with err_code 2'b10 in the next cycle and no write.
- R8: cmd_ready is low from acceptance of a read-modify-write command until its write or error has been issued; each accepted command yields exactly one of a write, an interrupt set or an error.
- R9: Kind 2'b11 drops the command and raises err_valid with err_code 2'b11 in the cycle after acceptance.
- R10: After reset cmd_ready is high and bank_rd_en, bank_wr_en, irq_set_en and err_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Dispatcher can accept a command |
| cmd_kind | input | 2 | Command kind: 00 interrupt, 01 mail, 10 any-send |
| cmd_data | input | 64 | Command word |
| bank_rd_en | output | 1 | Old-word read request, one cycle |
| bank_rd_core | output | 10 | Core of the read |
| bank_rd_addr | output | 16 | Register offset of the read |
| bank_rd_ack | input | 1 | Read response valid |
| bank_rd_err | input | 1 | Read response failed |
| bank_rd_data | input | 32 | Read response word |
| bank_wr_en | output | 1 | Word write strobe |
| bank_wr_core | output | 10 | Core of the write |
| bank_wr_addr | output | 16 | Register offset of the write |
| bank_wr_data | output | 32 | Word written |
| irq_set_en | output | 1 | Vector set strobe |
| irq_set_core | output | 10 | Core whose status is set |
| irq_set_mask | output | 32 | One-hot vector bit to set |
| err_valid | output | 1 | Command dropped strobe |
| err_code | output | 2 | 01 bad core, 10 read failure, 11 bad kind |

## Verification
The in-RTL assertions check on every cycle that a read request lasts one cycle and only while input is held off, that the strobes for write, interrupt and error never coincide, that only in-range cores are ever written or signalled, that an interrupt mask is one-hot and that a failed read is followed by an error rather than a write. Whether the offsets, merged bytes and error codes carry the right values, and that each command arrives on the right cycle, is shown only by the bench's scenarios, which compare every outcome against a bench model of the banks across random and directed commands including all-keep, alternate-byte masks, read failures and out-of-range cores.

// File: rtl/ipi_pkg.sv
// Shared types for the send command dispatcher.
// Assumes a 64-bit command word and 32-bit bank words.
package ipi_pkg;
    typedef enum logic [1:0] {
        KIND_IRQ  = 2'b00,
        KIND_MAIL = 2'b01,
        KIND_ANY  = 2'b10,
        KIND_RSVD = 2'b11
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'b00,
        ERR_BAD_CORE = 2'b01,
        ERR_RD_FAIL  = 2'b10,
        ERR_BAD_KIND = 2'b11
    } err_code_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RD   = 2'b01,
        ST_WAIT = 2'b10
    } disp_state_e;
endpackage

// File: rtl/ipi_cmd_decode.sv
// Splits a command word into target core, offset, payload, keep mask and
// vector mask. Purely combinational; assumes the field layout of the brief.
module ipi_cmd_decode #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 10,
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32,
    parameter int MAIL_BASE = 32
) (
    input  logic [1:0]          kind,
    input  logic [63:0]         data,
    output logic [CORE_W-1:0]   core,
    output logic                core_ok,
    output logic                kind_ok,
    output logic                is_irq,
    output logic [ADDR_W-1:0]   addr,
    output logic [WORD_W-1:0]   payload,
    output logic [WORD_W/8-1:0] keep,
    output logic [WORD_W-1:0]   vec_mask
);
    import ipi_pkg::*;

    localparam int NBYTES = WORD_W / 8;

    // Field extraction and address selection for each kind.
    always_comb begin
        core     = data[16 +: CORE_W];
        core_ok  = 32'(core) < NUM_CORES;
        kind_ok  = (kind != KIND_RSVD);
        is_irq   = (kind == KIND_IRQ);
        payload  = data[32 +: WORD_W];
        keep     = data[27 +: NBYTES];
        vec_mask = WORD_W'(1) << data[4:0];
        if (kind == KIND_MAIL)
            addr = ADDR_W'(MAIL_BASE) + ADDR_W'({data[4:2], 2'b00});
        else
            addr = data[ADDR_W-1:0];
    end
endmodule

// File: rtl/ipi_byte_merge.sv
// Builds the written word from the old word and the payload: byte i is
// taken from the old word when keep[i] is set. Combinational.
module ipi_byte_merge #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]   old_word,
    input  logic [WORD_W-1:0]   new_word,
    input  logic [WORD_W/8-1:0] keep,
    output logic [WORD_W-1:0]   merged
);
    localparam int NBYTES = WORD_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        // Per-byte choice between retained and fresh data.
        assign merged[b*8 +: 8] = keep[b] ? old_word[b*8 +: 8] : new_word[b*8 +: 8];
    end
endmodule

// File: rtl/ipi_send_dispatch.sv
// Send command dispatcher. Accepts one command at a time; interrupt sends,
// unmasked stores and rejected commands finish in the cycle after
// acceptance, masked stores perform a read-modify-write toward the banks.
// Assumes bank_rd_ack comes no earlier than the cycle after bank_rd_en.
module ipi_send_dispatch #(
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 10,
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_kind,
    input  logic [63:0]       cmd_data,
    output logic              bank_rd_en,
    output logic [CORE_W-1:0] bank_rd_core,
    output logic [ADDR_W-1:0] bank_rd_addr,
    input  logic              bank_rd_ack,
    input  logic              bank_rd_err,
    input  logic [WORD_W-1:0] bank_rd_data,
    output logic              bank_wr_en,
    output logic [CORE_W-1:0] bank_wr_core,
    output logic [ADDR_W-1:0] bank_wr_addr,
    output logic [WORD_W-1:0] bank_wr_data,
    output logic              irq_set_en,
    output logic [CORE_W-1:0] irq_set_core,
    output logic [WORD_W-1:0] irq_set_mask,
    output logic              err_valid,
    output logic [1:0]        err_code
);
    import ipi_pkg::*;

    localparam int NBYTES = WORD_W / 8;

    disp_state_e        st;
    logic [CORE_W-1:0]  d_core;
    logic               d_core_ok, d_kind_ok, d_is_irq;
    logic [ADDR_W-1:0]  d_addr;
    logic [WORD_W-1:0]  d_payload, d_vec;
    logic [NBYTES-1:0]  d_keep;
    logic [CORE_W-1:0]  h_core;
    logic [ADDR_W-1:0]  h_addr;
    logic [WORD_W-1:0]  h_payload, merged;
    logic [NBYTES-1:0]  h_keep;
    logic               accept;

    ipi_cmd_decode #(
        .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W),
        .WORD_W(WORD_W), .MAIL_BASE(32)
    ) u_dec (
        .kind(cmd_kind), .data(cmd_data), .core(d_core), .core_ok(d_core_ok),
        .kind_ok(d_kind_ok), .is_irq(d_is_irq), .addr(d_addr),
        .payload(d_payload), .keep(d_keep), .vec_mask(d_vec)
    );

    ipi_byte_merge #(.WORD_W(WORD_W)) u_merge (
        .old_word(bank_rd_data), .new_word(h_payload), .keep(h_keep),
        .merged(merged)
    );

    // Handshake and read request follow the state directly.
    assign cmd_ready    = (st == ST_IDLE);
    assign accept       = cmd_valid && cmd_ready;
    assign bank_rd_en   = (st == ST_RD);
    assign bank_rd_core = h_core;
    assign bank_rd_addr = h_addr;

    // Command sequencing and registered result strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= ST_IDLE;
            h_core       <= '0;
            h_addr       <= '0;
            h_payload    <= '0;
            h_keep       <= '0;
            bank_wr_en   <= 1'b0;
            bank_wr_core <= '0;
            bank_wr_addr <= '0;
            bank_wr_data <= '0;
            irq_set_en   <= 1'b0;
            irq_set_core <= '0;
            irq_set_mask <= '0;
            err_valid    <= 1'b0;
            err_code     <= ERR_NONE;
        end else begin
            bank_wr_en <= 1'b0;
            irq_set_en <= 1'b0;
            err_valid  <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        h_core    <= d_core;
                        h_addr    <= d_addr;
                        h_payload <= d_payload;
                        h_keep    <= d_keep;
                        if (!d_kind_ok) begin
                            err_valid <= 1'b1;
                            err_code  <= ERR_BAD_KIND;
                        end else if (!d_core_ok) begin
                            err_valid <= 1'b1;
                            err_code  <= ERR_BAD_CORE;
                        end else if (d_is_irq) begin
                            irq_set_en   <= 1'b1;
                            irq_set_core <= d_core;
                            irq_set_mask <= d_vec;
                        end else if (d_keep == '0) begin
                            bank_wr_en   <= 1'b1;
                            bank_wr_core <= d_core;
                            bank_wr_addr <= d_addr;
                            bank_wr_data <= d_payload;
                        end else begin
                            st <= ST_RD;
                        end
                    end
                end
                ST_RD, ST_WAIT: begin
                    if (bank_rd_ack) begin
                        st <= ST_IDLE;
                        if (bank_rd_err) begin
                            err_valid <= 1'b1;
                            err_code  <= ERR_RD_FAIL;
                        end else begin
                            bank_wr_en   <= 1'b1;
                            bank_wr_core <= h_core;
                            bank_wr_addr <= h_addr;
                            bank_wr_data <= merged;
                        end
                    end else begin
                        st <= ST_WAIT;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // A read request lasts a single cycle.
    assert_rd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd_en |=> !bank_rd_en);

    // No command is taken while a read is outstanding.
    assert_ready_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd_en |-> !cmd_ready);

    // One result kind per cycle.
    assert_one_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bank_wr_en, irq_set_en, err_valid}));

    // Only existing cores are written or signalled.
    assert_core_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr_en |-> 32'(bank_wr_core) < NUM_CORES) and
        (irq_set_en |-> 32'(irq_set_core) < NUM_CORES));

    // An interrupt set names exactly one vector.
    assert_irq_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_en |-> $countones(irq_set_mask) == 1);

    // A failed read ends in an error and never a write.
    assert_rderr_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd_ack && bank_rd_err && !cmd_ready) |=>
            (err_valid && err_code == ERR_RD_FAIL && !bank_wr_en));
endmodule

// File: tb/ipi_send_dispatch_tb.sv
// Bench: directed corners plus seeded random commands against a bank model.
module ipi_send_dispatch_tb;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready;
    logic [1:0]  cmd_kind = '0;
    logic [63:0] cmd_data = '0;
    logic        bank_rd_en, bank_rd_ack = 1'b0, bank_rd_err = 1'b0;
    logic [9:0]  bank_rd_core, bank_wr_core, irq_set_core;
    logic [15:0] bank_rd_addr, bank_wr_addr;
    logic [31:0] bank_rd_data = '0, bank_wr_data, irq_set_mask;
    logic        bank_wr_en, irq_set_en, err_valid;
    logic [1:0]  err_code;

    int tests = 0, fails = 0;
    logic [31:0] mem [N][64];
    bit  rderr_mode = 0;
    int  pend = 0, rd_seen = 0;
    logic [9:0]  rd_core_seen;
    logic [15:0] rd_addr_seen;

    always #10 clk = ~clk;

    ipi_send_dispatch #(.NUM_CORES(N)) u_dut (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_kind, .cmd_data,
        .bank_rd_en, .bank_rd_core, .bank_rd_addr, .bank_rd_ack, .bank_rd_err,
        .bank_rd_data, .bank_wr_en, .bank_wr_core, .bank_wr_addr, .bank_wr_data,
        .irq_set_en, .irq_set_core, .irq_set_mask, .err_valid, .err_code
    );

    // Bank model: answers reads after 1..3 cycles, applies writes.
    always @(negedge clk) begin
        bank_rd_ack = 1'b0;
        if (pend == 1) begin
            bank_rd_ack  = 1'b1;
            bank_rd_err  = rderr_mode;
            bank_rd_data = mem[rd_core_seen % N][rd_addr_seen[7:2]];
        end
        if (pend > 0) pend = pend - 1;
        if (bank_rd_en) begin
            rd_seen++;
            rd_core_seen = bank_rd_core;
            rd_addr_seen = bank_rd_addr;
            pend = 1 + int'($urandom % 3);
        end
        if (bank_wr_en && bank_wr_core < N)
            mem[bank_wr_core][bank_wr_addr[7:2]] = bank_wr_data;
    end

    function automatic logic [31:0] merge_f(logic [31:0] o, logic [31:0] n, logic [3:0] k);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[b*8 +: 8] = k[b] ? o[b*8 +: 8] : n[b*8 +: 8];
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one command and compare its outcome with the bench model.
    task automatic run_cmd(logic [1:0] kind, logic [63:0] d, bit rderr);
        logic [9:0]  core = d[25:16];
        logic [15:0] addr;
        logic [3:0]  keep = d[30:27];
        logic [31:0] pay = d[63:32];
        logic [31:0] old;
        int exp_kind;  // 0 irq, 1 write, 2 error
        logic [1:0] exp_err = 2'b00;
        logic [31:0] exp_word = '0;
        bit rmw = 0;
        int k;
        @(negedge clk);
        addr = (kind == 2'b01) ? 16'h20 + 16'({d[4:2], 2'b00}) : d[15:0];
        old = mem[core % N][addr[7:2]];
        if (kind == 2'b11) begin exp_kind = 2; exp_err = 2'b11; end
        else if (core >= N) begin exp_kind = 2; exp_err = 2'b01; end
        else if (kind == 2'b00) exp_kind = 0;
        else if (keep == 0) begin exp_kind = 1; exp_word = pay; end
        else begin
            rmw = 1;
            if (rderr) begin exp_kind = 2; exp_err = 2'b10; end
            else begin exp_kind = 1; exp_word = merge_f(old, pay, keep); end
        end
        rderr_mode = rderr;
        rd_seen = 0;
        cmd_kind = kind; cmd_data = d; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        k = 0;
        while (!(bank_wr_en || irq_set_en || err_valid) && k < 30) begin
            check(cmd_ready == 1'b0, "R8", "ready during rmw", cmd_ready, 0);
            @(negedge clk);
            k++;
        end
        if (!rmw) check(k == 0, "R5", "result cycle", k, 0);
        check(k < 30, "R8", "result seen", k, 0);
        if (rmw) begin
            check(rd_seen == 1, "R6", "read count", rd_seen, 1);
            check(rd_core_seen == core && rd_addr_seen == addr, "R6", "read target",
                  {rd_core_seen, rd_addr_seen}, {core, addr});
        end else check(rd_seen == 0, "R5", "no read", rd_seen, 0);
        case (exp_kind)
            0: check(irq_set_en && irq_set_core == core && irq_set_mask == 32'd1 << d[4:0],
                     "R2", "irq set", {irq_set_en, irq_set_core, irq_set_mask},
                     {1'b1, core, 32'd1 << d[4:0]});
            1: check(bank_wr_en && bank_wr_core == core && bank_wr_addr == addr &&
                     bank_wr_data == exp_word, kind == 2'b01 ? "R3" : "R4", "write",
                     {bank_wr_en, bank_wr_core, bank_wr_addr, bank_wr_data},
                     {1'b1, core, addr, exp_word});
            default: check(err_valid && err_code == exp_err && !bank_wr_en && !irq_set_en,
                     exp_err == 2'b01 ? "R1" : exp_err == 2'b10 ? "R7" : "R9", "error",
                     {err_valid, err_code, bank_wr_en}, {1'b1, exp_err, 1'b0});
        endcase
    endtask

    function automatic logic [63:0] mk(logic [31:0] pay, logic [3:0] keep, logic [9:0] core, logic [15:0] lo);
        return {pay, 1'b0, keep, 1'b0, core, lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < N; c++)
            for (int w = 0; w < 64; w++) mem[c][w] = $urandom;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cmd_ready && !bank_rd_en && !bank_wr_en && !irq_set_en && !err_valid,
              "R10", "reset state", {cmd_ready, bank_rd_en, bank_wr_en, irq_set_en, err_valid}, 5'b10000);
        rst_n = 1'b1;
        // R2 vector corners
        run_cmd(2'b00, mk(32'h0, 4'h0, 10'd1, 16'h0000), 0);
        run_cmd(2'b00, mk(32'h0, 4'h0, 10'd3, 16'h001f), 0);
        // R3 slot 7 and R5 direct write
        run_cmd(2'b01, mk(32'hdeadbeef, 4'h0, 10'd2, 16'h001c), 0);
        // R4 any-send, R6 all-keep and alternate-byte masks
        run_cmd(2'b10, mk(32'h11223344, 4'hf, 10'd0, 16'h0044), 0);
        run_cmd(2'b10, mk(32'haabbccdd, 4'h5, 10'd1, 16'h0108), 0);
        run_cmd(2'b01, mk(32'h01020304, 4'h8, 10'd3, 16'h0000), 0);
        // R7 read failure
        run_cmd(2'b01, mk(32'hcafef00d, 4'h2, 10'd0, 16'h0004), 1);
        // R1 first nonexistent core and the largest core number
        run_cmd(2'b00, mk(32'h0, 4'h0, 10'(N), 16'h0003), 0);
        run_cmd(2'b10, mk(32'h12345678, 4'h3, 10'h3ff, 16'h0010), 0);
        // R9 reserved kind
        run_cmd(2'b11, mk(32'h0, 4'h1, 10'd0, 16'h0000), 0);
        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [63:0] d = {$urandom, $urandom};
            d[25:16] = 10'($urandom % (N + 2));
            if ($urandom % 3 == 0) d[30:27] = 4'h0;
            run_cmd(2'($urandom % 4), d, ($urandom % 8) == 0);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule